// File: doc/BRIEF.md
# Scroll and VRAM Address Registers

This block keeps the scroll position of a tile-based video generator. It holds a 15-bit live video-memory address, a 15-bit staging address that collects scroll fields, a 3-bit fine horizontal offset and a single toggle. The toggle decides whether a write to the scroll or address register is the first or the second of a pair. A processor-side port writes the control, scroll and address registers and reads the status register. Each access is one cycle long.

A render-side port delivers one-cycle strobes that step the live address as tiles and lines are fetched: step one tile across, step one line down, reload the horizontal fields, and reload everything. A data-port strobe moves the live address on by one or by one row after each data access. The live address, the staging address and the fine offset are outputs. The memory fetches, the pixel pipeline and the timing of the strobes belong to neighbouring blocks.

Address layout used throughout: bits 4:0 are coarse X, bits 9:5 are coarse Y, bit 10 is the horizontal table select, bit 11 is the vertical table select, and bits 14:12 are fine Y. Register select codes are 0 for control, 1 for scroll, 2 for address and 3 for status.

Top module: `scroll_addr_regs`

## Requirements
- R1: A control write (select 0) copies data bits 1:0 into staging bits 11:10 and leaves the other staging bits unchanged. Data bit 2 is stored as the row-step flag.
- R2: A first scroll write (select 1) puts data 7:3 into staging 4:0 and data 2:0 into fine X. A second scroll write puts data 2:0 into staging 14:12 and data 7:3 into staging 9:5, and keeps staging 11:10 and 4:0.
- R3: A first address write (select 2) puts data 5:0 into staging 13:8, clears staging bit 14 and keeps staging 7:0. A second address write puts the data into staging 7:0 and loads the whole new staging value into the live address. A first write leaves the live address unchanged.
- R4: The scroll and address registers share one toggle, which flips on every write to either of them. A status read (select 3 with the read strobe) clears the toggle. A write with select 3 has no effect.
- R5: A horizontal step adds one to coarse X modulo 32. When coarse X wraps to 0, bit 10 is inverted. All other bits are kept.
- R6: A vertical step adds one to fine Y. When fine Y wraps from 7 to 0, coarse Y advances.
- R7: When coarse Y advances from 29, it becomes 0 and bit 11 is inverted. When it advances from 31, it becomes 0 and bit 11 is kept. Any other row simply advances.
- R8: A horizontal reload copies staging bits 10 and 4:0 into the live address and keeps the rest. A vertical reload copies the whole staging address.
- R9: A data-port strobe adds 32 to the live address when the row-step flag is 1 and adds 1 otherwise, modulo 2^15.
- R10: A synchronous reset clears the live address, the staging address, fine X, the toggle and the row-step flag.
- R11: A second address write takes priority over every strobe in the same cycle. Among the strobes, the order is vertical reload, then horizontal reload, then vertical step, then horizontal step, then data-port step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_sel | input | 2 | Register select: 0 control, 1 scroll, 2 address, 3 status |
| cpu_wdata | input | 8 | Write data |
| data_step | input | 1 | Data-port access strobe |
| h_step | input | 1 | Horizontal tile step strobe |
| v_step | input | 1 | Vertical line step strobe |
| h_reload | input | 1 | Horizontal reload strobe |
| v_reload | input | 1 | Vertical reload strobe |
| vaddr_o | output | 15 | Live address |
| taddr_o | output | 15 | Staging address |
| fine_x_o | output | 3 | Fine horizontal offset |

## Verification
The toggle has no port of its own. A wrong toggle shows only on the next scroll or address write, which then lands in the wrong field or fails to load the live address. That error appears on the outputs one cycle after that write. A wrong staging or row-step value becomes visible only after a later reload or data step, so every staging check is paired with a reload that brings the staging value out through the live address. The row-29 and row-31 wraps and the coarse-X wrap appear as a wrong table-select bit one cycle after the step, which is why every row, fine line and table select is swept.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_SCROLL = 2'd1,
      SEL_ADDR   = 2'd2,
      SEL_STATUS = 2'd3
   } reg_sel_e;

   // position of the row-step flag in a control write
   localparam int unsigned ROW_STEP_BIT = 2;

endpackage

// File: rtl/scroll_latch_unit.sv
module scroll_latch_unit
   import scroll_pkg::*;
#(
   parameter int unsigned CX_W   = 5,
   parameter int unsigned FY_W   = 3,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned ADDR_W = FY_W + 2 + 2 * CX_W
) (
   input  logic              wr,
   input  logic              rd,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] data,
   input  logic [ADDR_W-1:0] t_in,
   input  logic [FY_W-1:0]   fx_in,
   input  logic              tog_in,
   input  logic              row_in,
   output logic [ADDR_W-1:0] t_next,
   output logic [FY_W-1:0]   fx_next,
   output logic              tog_next,
   output logic              row_next,
   output logic              load_v
);

   localparam int unsigned CY_LO = CX_W;
   localparam int unsigned NTX   = 2 * CX_W;
   localparam int unsigned NTY   = 2 * CX_W + 1;
   localparam int unsigned FY_LO = 2 * CX_W + 2;
   localparam int unsigned HI_W  = ADDR_W - 1 - DATA_W;

   reg_sel_e sel_e;
   assign sel_e = reg_sel_e'(sel);

   always_comb begin
      t_next   = t_in;
      fx_next  = fx_in;
      tog_next = tog_in;
      row_next = row_in;
      load_v   = 1'b0;
      if (rd && sel_e == SEL_STATUS) begin
         tog_next = 1'b0;
      end
      if (wr) begin
         case (sel_e)
            SEL_CTRL: begin
               t_next[NTY:NTX] = data[1:0];
               row_next        = data[ROW_STEP_BIT];
            end
            SEL_SCROLL: begin
               if (!tog_in) begin
                  t_next[CX_W-1:0] = data[DATA_W-1:FY_W];
                  fx_next          = data[FY_W-1:0];
               end else begin
                  t_next[FY_LO +: FY_W] = data[FY_W-1:0];
                  t_next[CY_LO +: CX_W] = data[DATA_W-1:FY_W];
               end
               tog_next = ~tog_in;
            end
            SEL_ADDR: begin
               if (!tog_in) begin
                  t_next[DATA_W +: HI_W] = data[HI_W-1:0];
                  t_next[ADDR_W-1]       = 1'b0;
               end else begin
                  t_next[DATA_W-1:0] = data;
                  load_v             = 1'b1;
               end
               tog_next = ~tog_in;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/scroll_walk_unit.sv
module scroll_walk_unit #(
   parameter int unsigned CX_W         = 5,
   parameter int unsigned FY_W         = 3,
   parameter int unsigned LAST_ROW     = 29,
   parameter bit          ROW_LIMIT_EN = 1'b1,
   localparam int unsigned ADDR_W = FY_W + 2 + 2 * CX_W
) (
   input  logic [ADDR_W-1:0] v_in,
   input  logic [ADDR_W-1:0] t_in,
   input  logic              row_step,
   input  logic              data_step,
   input  logic              h_step,
   input  logic              v_step,
   input  logic              h_reload,
   input  logic              v_reload,
   output logic [ADDR_W-1:0] v_next
);

   localparam int unsigned CY_LO = CX_W;
   localparam int unsigned NTX   = 2 * CX_W;
   localparam int unsigned NTY   = 2 * CX_W + 1;
   localparam int unsigned FY_LO = 2 * CX_W + 2;
   localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_ROW = ADDR_W'(1) << CX_W;
   localparam logic [CX_W-1:0]   LAST_V   = CX_W'(LAST_ROW);

   logic [CX_W-1:0]   cy;
   logic [FY_W-1:0]   fy;
   logic [CX_W-1:0]   cx;
   logic              row_hit;
   logic [ADDR_W-1:0] vert_v;
   logic [ADDR_W-1:0] horz_v;

   assign cy = v_in[CY_LO +: CX_W];
   assign fy = v_in[FY_LO +: FY_W];
   assign cx = v_in[CX_W-1:0];

   generate
      if (ROW_LIMIT_EN) begin : g_row_limit
         assign row_hit = (cy == LAST_V);
      end else begin : g_row_plain
         assign row_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      vert_v = v_in;
      if (fy != {FY_W{1'b1}}) begin
         vert_v[FY_LO +: FY_W] = fy + FY_W'(1);
      end else begin
         vert_v[FY_LO +: FY_W] = '0;
         if (row_hit) begin
            vert_v[CY_LO +: CX_W] = '0;
            vert_v[NTY]           = ~v_in[NTY];
         end else begin
            vert_v[CY_LO +: CX_W] = cy + CX_W'(1);
         end
      end
   end

   always_comb begin
      horz_v = v_in;
      horz_v[CX_W-1:0] = cx + CX_W'(1);
      if (cx == {CX_W{1'b1}}) begin
         horz_v[NTX] = ~v_in[NTX];
      end
   end

   always_comb begin
      v_next = v_in;
      if (v_reload) begin
         v_next = t_in;
      end else if (h_reload) begin
         v_next[CX_W-1:0] = t_in[CX_W-1:0];
         v_next[NTX]      = t_in[NTX];
      end else if (v_step) begin
         v_next = vert_v;
      end else if (h_step) begin
         v_next = horz_v;
      end else if (data_step) begin
         v_next = v_in + (row_step ? STEP_ROW : STEP_ONE);
      end
   end

endmodule

// File: rtl/scroll_addr_regs.sv
module scroll_addr_regs
   import scroll_pkg::*;
#(
   parameter int unsigned CX_W         = 5,
   parameter int unsigned FY_W         = 3,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned LAST_ROW     = 29,
   parameter bit          ROW_LIMIT_EN = 1'b1,
   localparam int unsigned ADDR_W = FY_W + 2 + 2 * CX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [1:0]        cpu_sel,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              data_step,
   input  logic              h_step,
   input  logic              v_step,
   input  logic              h_reload,
   input  logic              v_reload,
   output logic [ADDR_W-1:0] vaddr_o,
   output logic [ADDR_W-1:0] taddr_o,
   output logic [FY_W-1:0]   fine_x_o
);

   localparam int unsigned NTX   = 2 * CX_W;
   localparam int unsigned NTY   = 2 * CX_W + 1;
   localparam int unsigned CY_LO = CX_W;
   localparam int unsigned FY_LO = 2 * CX_W + 2;

   generate
      if (DATA_W != CX_W + FY_W) begin : g_bad_data_w
         $error("scroll_addr_regs: DATA_W must equal CX_W + FY_W");
      end
      if (ADDR_W <= DATA_W + 1) begin : g_bad_addr_w
         $error("scroll_addr_regs: address too narrow for two-byte load");
      end
      if (LAST_ROW >= (1 << CX_W)) begin : g_bad_row
         $error("scroll_addr_regs: LAST_ROW out of coarse range");
      end
   endgenerate

   logic [ADDR_W-1:0] v_q, t_q, t_d, walk_v;
   logic [FY_W-1:0]   fx_q, fx_d;
   logic              tog_q, tog_d, row_q, row_d, load_v;

   scroll_latch_unit #(.CX_W(CX_W), .FY_W(FY_W), .DATA_W(DATA_W)) u_latch (
      .wr(cpu_wr), .rd(cpu_rd), .sel(cpu_sel), .data(cpu_wdata),
      .t_in(t_q), .fx_in(fx_q), .tog_in(tog_q), .row_in(row_q),
      .t_next(t_d), .fx_next(fx_d), .tog_next(tog_d), .row_next(row_d),
      .load_v(load_v)
   );

   scroll_walk_unit #(
      .CX_W(CX_W), .FY_W(FY_W), .LAST_ROW(LAST_ROW), .ROW_LIMIT_EN(ROW_LIMIT_EN)
   ) u_walk (
      .v_in(v_q), .t_in(t_q), .row_step(row_q), .data_step(data_step),
      .h_step(h_step), .v_step(v_step), .h_reload(h_reload),
      .v_reload(v_reload), .v_next(walk_v)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q   <= '0;
         t_q   <= '0;
         fx_q  <= '0;
         tog_q <= 1'b0;
         row_q <= 1'b0;
      end else begin
         v_q   <= load_v ? t_d : walk_v;
         t_q   <= t_d;
         fx_q  <= fx_d;
         tog_q <= tog_d;
         row_q <= row_d;
      end
   end

   assign vaddr_o  = v_q;
   assign taddr_o  = t_q;
   assign fine_x_o = fx_q;

   logic sel_status, sel_ctrl, addr_second, quiet_cpu, hstep_only, dstep_only;
   assign sel_status  = (cpu_sel == 2'(SEL_STATUS));
   assign sel_ctrl    = (cpu_sel == 2'(SEL_CTRL));
   assign addr_second = cpu_wr && (cpu_sel == 2'(SEL_ADDR)) && tog_q;
   assign quiet_cpu   = !addr_second;
   assign hstep_only  = h_step && !v_step && !h_reload && !v_reload && quiet_cpu;
   assign dstep_only  = data_step && !h_step && !v_step && !h_reload && !v_reload
                        && quiet_cpu;

   // R1
   ctrl_nt_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_wr && sel_ctrl |=> taddr_o[NTY:NTX] == $past(cpu_wdata[1:0]));

   // R4
   status_clear_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_rd && sel_status |=> !tog_q);

   // R5
   hstep_cx_chk: assert property (@(posedge clk) disable iff (rst)
      hstep_only |=> vaddr_o[CX_W-1:0] == CX_W'($past(vaddr_o[CX_W-1:0]) + 1)
                     && vaddr_o[NTY] == $past(vaddr_o[NTY])
                     && vaddr_o[FY_LO +: FY_W] == $past(vaddr_o[FY_LO +: FY_W])
                     && vaddr_o[CY_LO +: CX_W] == $past(vaddr_o[CY_LO +: CX_W]));

   // R8
   vreload_chk: assert property (@(posedge clk) disable iff (rst)
      v_reload && quiet_cpu |=> vaddr_o == $past(taddr_o));

   // R9
   dstep_chk: assert property (@(posedge clk) disable iff (rst)
      dstep_only |=> vaddr_o == ADDR_W'($past(vaddr_o)
                     + ($past(row_q) ? (ADDR_W'(1) << CX_W) : ADDR_W'(1))));

   // R11
   addr_prio_chk: assert property (@(posedge clk) disable iff (rst)
      addr_second |=> vaddr_o == taddr_o && !tog_q);

endmodule

// File: tb/tb_scroll_addr_regs.sv
module tb_scroll_addr_regs;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_wr = 0, cpu_rd = 0;
   logic [1:0]  cpu_sel = 0;
   logic [7:0]  cpu_wdata = 0;
   logic        data_step = 0, h_step = 0, v_step = 0, h_reload = 0, v_reload = 0;
   logic [14:0] vaddr_o, taddr_o;
   logic [2:0]  fine_x_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [14:0] et, ev;

   always #5 clk = ~clk;

   scroll_addr_regs dut (
      .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
      .cpu_wdata(cpu_wdata), .data_step(data_step), .h_step(h_step),
      .v_step(v_step), .h_reload(h_reload), .v_reload(v_reload),
      .vaddr_o(vaddr_o), .taddr_o(taddr_o), .fine_x_o(fine_x_o)
   );

   task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // one cycle: inputs set at a falling edge, cleared at the next one
   task automatic drive(input logic wr, input logic rd, input logic [1:0] sel,
                        input logic [7:0] d, input logic ds, input logic hs,
                        input logic vs, input logic hr, input logic vr);
      cpu_wr = wr; cpu_rd = rd; cpu_sel = sel; cpu_wdata = d;
      data_step = ds; h_step = hs; v_step = vs; h_reload = hr; v_reload = vr;
      @(negedge clk);
      cpu_wr = 0; cpu_rd = 0; cpu_sel = 0; cpu_wdata = 0;
      data_step = 0; h_step = 0; v_step = 0; h_reload = 0; v_reload = 0;
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [7:0] d);
      drive(1, 0, sel, d, 0, 0, 0, 0, 0);
   endtask

   task automatic status_rd();
      drive(0, 1, 2'd3, 8'h00, 0, 0, 0, 0, 0);
   endtask

   // stage a value through control and scroll writes, then vertical reload
   task automatic set_v(input logic [14:0] v, input logic rowf, input logic [2:0] fx);
      status_rd();
      wreg(2'd0, {5'b0, rowf, v[11:10]});
      wreg(2'd1, {v[4:0], fx});
      wreg(2'd1, {v[9:5], v[14:12]});
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
   endtask

   function automatic logic [14:0] vert_model(input logic [14:0] v);
      int fy = (v >> 12) & 7;
      int cy = (v >> 5) & 31;
      int nty = (v >> 11) & 1;
      if (fy < 7) return v + 15'h1000;
      fy = 0;
      if (cy == 29) begin cy = 0; nty = 1 - nty; end
      else cy = (cy + 1) % 32;
      return 15'((fy << 12) | (nty << 11) | (v & 15'h041F) | (cy << 5));
   endfunction

   function automatic logic [14:0] horz_model(input logic [14:0] v);
      int cx = v & 31;
      logic [14:0] r = v & 15'h7FE0;
      r = r | 15'((cx + 1) % 32);
      if (cx == 31) r = r ^ 15'h0400;
      return r;
   endfunction

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst = 0;
      // R10 reset state
      check("R10 v", vaddr_o, 15'h0);
      check("R10 t", taddr_o, 15'h0);
      check("R10 fx", {12'b0, fine_x_o}, 15'h0);

      // R1 control sweep
      set_v(15'h7FFF, 0, 3'd0);
      et = 15'h7FFF;
      for (int d = 0; d < 256; d++) begin
         wreg(2'd0, 8'(d));
         et = (et & 15'h73FF) | 15'((d & 3) << 10);
         check("R1 ctrl", taddr_o, et);
      end

      // R2 scroll pair sweep
      for (int d = 0; d < 256; d++) begin
         status_rd();
         wreg(2'd1, 8'(d));
         et = (et & 15'h7FE0) | 15'(d >> 3);
         check("R2 first t", taddr_o, et);
         check("R2 first fx", {12'b0, fine_x_o}, 15'(d & 7));
         wreg(2'd1, 8'(d ^ 8'hA5));
         et = (et & 15'h0C1F) | 15'(((d ^ 8'hA5) & 7) << 12)
              | 15'(((d ^ 8'hA5) >> 3) << 5);
         check("R2 second t", taddr_o, et);
      end

      // R3 address pair sweep
      for (int d = 0; d < 256; d++) begin
         status_rd();
         ev = vaddr_o;
         wreg(2'd2, 8'(d));
         et = (et & 15'h00FF) | 15'((d & 8'h3F) << 8);
         check("R3 first t", taddr_o, et);
         check("R3 first v kept", vaddr_o, ev);
         wreg(2'd2, 8'(255 - d));
         et = (et & 15'h7F00) | 15'(255 - d);
         check("R3 second t", taddr_o, et);
         check("R3 second v", vaddr_o, et);
      end

      // R4 shared toggle and status clear
      status_rd();
      wreg(2'd1, 8'h5B);
      wreg(2'd2, 8'h3C);
      et = (taddr_o);
      check("R4 shared toggle loads v", vaddr_o, et);
      check("R4 low byte", {7'b0, taddr_o[7:0]}, 15'h3C);
      wreg(2'd2, 8'h12);
      ev = vaddr_o;
      status_rd();
      wreg(2'd2, 8'h21);
      check("R4 cleared toggle first write", vaddr_o, ev);
      wreg(2'd3, 8'hFF);
      wreg(2'd2, 8'h44);
      check("R4 status write ignored", vaddr_o, 15'h2144);

      // R5 horizontal step sweep
      for (int cx = 0; cx < 32; cx++) begin
         for (int nt = 0; nt < 2; nt++) begin
            ev = 15'h5A60 | 15'(nt << 10) | 15'(cx);
            set_v(ev, 0, 3'd0);
            drive(0, 0, 0, 0, 0, 1, 0, 0, 0);
            check("R5 hstep", vaddr_o, horz_model(ev));
         end
      end

      // R6/R7 vertical step sweep over every line, row and table select
      for (int cy = 0; cy < 32; cy++) begin
         for (int fy = 0; fy < 8; fy++) begin
            for (int nt = 0; nt < 2; nt++) begin
               ev = 15'((fy << 12) | (nt << 11) | (cy << 5) | 15'h0415);
               set_v(ev, 0, 3'd0);
               drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
               if (fy == 7 && (cy == 29 || cy == 31))
                  check("R7 row wrap", vaddr_o, vert_model(ev));
               else
                  check("R6 vstep", vaddr_o, vert_model(ev));
            end
         end
      end
      set_v(15'h73A0, 0, 3'd0);
      drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
      check("R7 row 29 to 0 flips bit 11", vaddr_o, 15'h0800);
      set_v(15'h7BE0, 0, 3'd0);
      drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
      check("R7 row 31 to 0 keeps bit 11", vaddr_o, 15'h0800);

      // R8 horizontal reload
      set_v(15'h2A55, 0, 3'd0);
      status_rd();
      wreg(2'd0, 8'h02);
      wreg(2'd1, 8'hF8);
      wreg(2'd1, 8'h07);
      et = taddr_o;
      drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
      check("R8 hreload", vaddr_o, (15'h2A55 & 15'h7BE0) | (et & 15'h041F));
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
      check("R8 vreload", vaddr_o, et);

      // R9 data-port step
      set_v(15'h7FFF, 0, 3'd0);
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0);
      check("R9 step one wraps", vaddr_o, 15'h0000);
      set_v(15'h7FF0, 1, 3'd0);
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0);
      check("R9 step row wraps", vaddr_o, 15'h0010);
      set_v(15'h1234, 1, 3'd0);
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0);
      check("R9 step row", vaddr_o, 15'h1254);

      // R11 priorities
      set_v(15'h0000, 0, 3'd0);
      status_rd();
      wreg(2'd2, 8'h15);
      drive(1, 0, 2'd2, 8'h67, 1, 1, 1, 1, 1);
      check("R11 address write wins", vaddr_o, 15'h1567);
      set_v(15'h1234, 0, 3'd0);
      status_rd();
      wreg(2'd1, 8'h00);
      et = taddr_o;
      drive(0, 0, 0, 0, 1, 1, 1, 0, 1);
      check("R11 vreload wins", vaddr_o, et);
      set_v(15'h1234, 0, 3'd0);
      status_rd();
      wreg(2'd1, 8'hF8);
      et = taddr_o;
      drive(0, 0, 0, 0, 1, 1, 1, 1, 0);
      check("R11 hreload over steps", vaddr_o, (15'h1234 & 15'h7BE0) | (et & 15'h041F));
      set_v(15'h7000, 0, 3'd0);
      drive(0, 0, 0, 0, 1, 1, 1, 0, 0);
      check("R11 vstep over hstep", vaddr_o, 15'h0020);

      // R10 reset mid-run
      rst = 1;
      @(negedge clk);
      rst = 0;
      check("R10 v after reset", vaddr_o, 15'h0);
      check("R10 t after reset", taddr_o, 15'h0);
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0);
      check("R10 row flag cleared", vaddr_o, 15'h0001);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule